// File: doc/BRIEF.md
# Fault Recovery Pulse Sequencer

This block watches an active-low fault flag raised by a power output stage on over-current or over-temperature. While the flag stays asserted, it drives a recovery control line low for one millisecond and then releases it high. After a short settle gap it samples the flag again and, if the fault is still there, issues another pulse. The cycle repeats until the stage reports healthy.

An active-low interrupt line tells the rest of the system that a fault is in progress. It stays asserted until the flag has read clear for a full settle interval, so brief gaps in the fault do not make it chatter. A level status output gives the synchronized fault state to mute or fade logic. A bypass input stops new recovery pulses from starting. Interrupt reporting is unchanged while bypass is set.

The hold length is CLK_HZ/1000 clock cycles, where CLK_HZ is a module parameter. The settle gap is SETTLE_CYC cycles, 16 by default.

Top module: `fault_recovery_seq`

## Requirements
- R1: While reset is held, and right after it, recov_n is 1, irq_n is 1 and fault_active is 0.
- R2: fault_n_in is active low (0 means fault) and passes through two synchronizing flops. fault_active equals the inverse of fault_n_in as it was two rising clock edges earlier.
- R3: When the sequencer is idle, the first clock edge that samples fault_active high with bypass_en low drives recov_n to 0. recov_n then stays 0 for exactly CLK_HZ/1000 cycles and returns to 1.
- R4: After each release, recov_n stays 1 for exactly SETTLE_CYC cycles. At the edge that ends this gap, a new pulse starts if fault_active is 1 and bypass_en is 0; otherwise the sequencer goes idle and recov_n stays 1.
- R5: irq_n goes to 0 at the first clock edge that samples fault_active high, and it stays 0 for as long as fault_active is high.
- R6: irq_n returns to 1 at the clock edge that samples fault_active low for the SETTLE_CYC-th consecutive time. Any high sample restarts the count.
- R7: A pulse cannot start at an edge where bypass_en is 1. A pulse already running completes. bypass_en has no effect on irq_n or fault_active.
- R8: If the fault clears partway through a pulse, the pulse is not shortened. It still lasts CLK_HZ/1000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_n_in | input | 1 | Fault flag from the power stage, 0 means fault |
| bypass_en | input | 1 | When 1, no new recovery pulse starts |
| recov_n | output | 1 | Recovery control, 0 commands the stage to recover |
| irq_n | output | 1 | Active-low fault interrupt |
| fault_active | output | 1 | Synchronized fault level, 1 while a fault is seen |

## Verification
The bench targets the following corner cases:
- A fault that clears in the middle of a pulse. A design that aborts the pulse early produces a short recovery command.
- A fault that persists across the settle gap. A design that gets the gap wrong either leaves the stage no time to settle or misses the re-sample and stops retrying.
- Bypass and clearing timing. With bypass held, the interrupt must still fall. It must release exactly at the SETTLE_CYC-th clear sample; a counter that is off by one, or that is not restarted by a glitch, releases it a cycle early or late.
- Random fault trains and bypass toggles, compared every cycle against an independent bench model. This exposes a wrong synchronizer depth through a one-cycle shift of every output.

// File: rtl/frps_pkg.sv
package frps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_GAP  = 2'd2
  } phase_t;

  // Cycles in one recovery hold: one millisecond at clk_hz, never below one.
  function automatic int unsigned hold_cycles(input int unsigned clk_hz);
    return (clk_hz < 1000) ? 1 : clk_hz / 1000;
  endfunction

  // Bits needed for a counter that runs 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frps_sync.sv
module frps_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= RESET_VAL;
        else        shreg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= {STAGES{RESET_VAL}};
        else        shreg <= {shreg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shreg[STAGES-1];

endmodule

// File: rtl/frps_pulse_seq.sv
module frps_pulse_seq
  import frps_pkg::*;
#(
  parameter int unsigned HOLD_CYC   = 1000,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_seen,
  input  logic bypass_en,
  output logic recov_n,
  output logic start_evt,
  output logic release_evt
);

  localparam int unsigned CW = cnt_width(max_u(HOLD_CYC, SETTLE_CYC));
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(SETTLE_CYC - 1);

  phase_t        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          want;
  logic          hold_done;
  logic          gap_done;

  assign want      = fault_seen & ~bypass_en;
  assign hold_done = (phase_q == PH_LOW) && (cnt_q == HOLD_LAST);
  assign gap_done  = (phase_q == PH_GAP) && (cnt_q == GAP_LAST);

  assign start_evt   = want && ((phase_q == PH_IDLE) || gap_done);
  assign release_evt = hold_done;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_evt) phase_d = PH_LOW;
      end
      PH_LOW: begin
        if (hold_done) begin
          phase_d = PH_GAP;
          cnt_d   = '0;
        end
      end
      PH_GAP: begin
        if (gap_done) begin
          phase_d = start_evt ? PH_LOW : PH_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign recov_n = (phase_q != PH_LOW);

endmodule

// File: rtl/frps_irq_track.sv
module frps_irq_track
  import frps_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_seen,
  output logic irq_act
);

  localparam int unsigned CW = cnt_width(SETTLE_CYC);
  localparam logic [CW-1:0] QUIET_LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_act <= 1'b0;
      quiet_q <= '0;
    end else if (fault_seen) begin
      irq_act <= 1'b1;
      quiet_q <= '0;
    end else if (irq_act) begin
      if (quiet_q == QUIET_LAST) begin
        irq_act <= 1'b0;
        quiet_q <= '0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
  import frps_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n_in,
  input  logic bypass_en,
  output logic recov_n,
  output logic irq_n,
  output logic fault_active
);

  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ);

  logic healthy_sync;
  logic fault_seen;
  logic irq_act;
  logic start_evt;
  logic release_evt;

  frps_sync #(
    .STAGES   (2),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (fault_n_in),
    .dout (healthy_sync)
  );

  assign fault_seen = ~healthy_sync;

  frps_pulse_seq #(
    .HOLD_CYC  (HOLD_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_seen (fault_seen),
    .bypass_en  (bypass_en),
    .recov_n    (recov_n),
    .start_evt  (start_evt),
    .release_evt(release_evt)
  );

  frps_irq_track #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_seen(fault_seen),
    .irq_act   (irq_act)
  );

  assign irq_n        = ~irq_act;
  assign fault_active = fault_seen;

endmodule

// File: rtl/fault_recovery_seq_chk.sv
module fault_recovery_seq_chk
  import frps_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic bypass_en,
  input logic recov_n,
  input logic irq_n,
  input logic fault_active,
  input logic start_evt,
  input logic release_evt
);

  localparam int unsigned HOLD_CYC = hold_cycles(CLK_HZ);

  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= SETTLE_CYC;
    end else if (!recov_n) begin
      low_run  <= low_run + 1;
      high_run <= '0;
    end else begin
      low_run  <= '0;
      high_run <= (high_run >= SETTLE_CYC) ? high_run : high_run + 1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_n) |-> (low_run == HOLD_CYC)); // R3

  AST_START_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !recov_n); // R3

  AST_RELEASE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> recov_n); // R8

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recov_n) |-> (high_run >= SETTLE_CYC)); // R4

  AST_IRQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_active |=> !irq_n); // R5

  AST_NO_START_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recov_n) |-> ($past(fault_active) && !$past(bypass_en))); // R7

endmodule

bind fault_recovery_seq fault_recovery_seq_chk #(
  .CLK_HZ    (CLK_HZ),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bypass_en   (bypass_en),
  .recov_n     (recov_n),
  .irq_n       (irq_n),
  .fault_active(fault_active),
  .start_evt   (start_evt),
  .release_evt (release_evt)
);

// File: tb/fault_recovery_seq_test.sv
module fault_recovery_seq_test;

  localparam int unsigned CLK_HZ = 40_000;
  localparam int unsigned SET    = 16;

  function automatic int exp_hold(input int unsigned hz);
    int h;
    h = hz / 1000;
    if (h < 1) h = 1;
    return h;
  endfunction

  localparam int HOLD = exp_hold(CLK_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_n_in = 1'b1;
  logic bypass_en = 1'b0;
  logic recov_n, irq_n, fault_active;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fault_recovery_seq #(.CLK_HZ(CLK_HZ), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst_n(rst_n), .fault_n_in(fault_n_in), .bypass_en(bypass_en),
    .recov_n(recov_n), .irq_n(irq_n), .fault_active(fault_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Bench model: pulse phase with a down-counter, a quiet-sample tally for the interrupt,
  // and a two-deep delay line for the fault input.
  int m_mode, m_left, m_quiet;
  bit m_d1, m_d2, m_irq, m_flt, m_go;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 = 1'b1; m_d2 = 1'b1; m_mode = 0; m_left = 0; m_irq = 1'b0; m_quiet = 0;
    end else begin
      m_flt = !m_d2;
      m_go  = m_flt && !bypass_en;
      if (m_mode == 0) begin
        if (m_go) begin m_mode = 1; m_left = HOLD; end
      end else if (m_mode == 1) begin
        m_left--;
        if (m_left == 0) begin m_mode = 2; m_left = SET; end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_go) begin m_mode = 1; m_left = HOLD; end
          else m_mode = 0;
        end
      end
      if (m_flt) begin
        m_irq = 1'b1; m_quiet = 0;
      end else if (m_irq) begin
        m_quiet++;
        if (m_quiet == SET) begin m_irq = 1'b0; m_quiet = 0; end
      end
      m_d2 = m_d1;
      m_d1 = fault_n_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 R4 R7 R8 recov_n vs model", recov_n, (m_mode == 1) ? 0 : 1);
      chk("R5 R6 irq_n vs model", irq_n, m_irq ? 0 : 1);
      chk("R2 fault_active vs model", fault_active, m_d2 ? 0 : 1);
    end
  end

  initial begin
    #(200_000 * 10 - 100);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int len;
    int lows;
    void'($urandom(32'd4711));

    // R1: outputs under reset and right after release
    repeat (3) @(negedge clk);
    chk("R1 recov_n in reset", recov_n, 1);
    chk("R1 irq_n in reset", irq_n, 1);
    chk("R1 fault_active in reset", fault_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 recov_n after reset", recov_n, 1);
    chk("R1 irq_n after reset", irq_n, 1);
    cmp_en = 1'b1;
    repeat (4) @(negedge clk);

    // R7 and R6: bypass held, interrupt still reports, then releases on time
    bypass_en = 1'b1;
    fault_n_in = 1'b0;
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!recov_n) lows++;
    end
    chk("R7 no pulse under bypass", lows, 0);
    chk("R7 irq_n under bypass", irq_n, 0);
    fault_n_in = 1'b1;
    for (int k = 1; k <= SET + 2; k++) begin
      @(negedge clk);
      if (k == SET + 1) chk("R6 irq_n one sample early", irq_n, 0);
      if (k == SET + 2) chk("R6 irq_n at last quiet sample", irq_n, 1);
    end
    bypass_en = 1'b0;
    repeat (5) @(negedge clk);

    // R2, R3, R5: latency and pulse width
    fault_n_in = 1'b0;
    @(negedge clk);
    chk("R2 fault_active after one edge", fault_active, 0);
    @(negedge clk);
    chk("R2 fault_active after two edges", fault_active, 1);
    chk("R3 recov_n before start", recov_n, 1);
    @(negedge clk);
    chk("R3 recov_n at start", recov_n, 0);
    chk("R5 irq_n at start", irq_n, 0);
    len = 1;
    @(negedge clk);
    while (!recov_n && len < 10 * HOLD) begin len++; @(negedge clk); end
    chk("R3 pulse width", len, HOLD);

    // R4: gap length with fault still present, then retry
    len = 0;
    while (recov_n && len < 10 * SET) begin len++; @(negedge clk); end
    chk("R4 settle gap", len, SET);

    // R8: fault clears during the second pulse
    fault_n_in = 1'b1;
    len = 1;
    @(negedge clk);
    while (!recov_n && len < 10 * HOLD) begin len++; @(negedge clk); end
    chk("R8 pulse not shortened", len, HOLD);
    lows = 0;
    for (int i = 0; i < SET + 20; i++) begin
      @(negedge clk);
      if (!recov_n) lows++;
    end
    chk("R4 idle after cleared fault", lows, 0);
    chk("R6 irq_n after clear", irq_n, 1);

    // Random fault trains and bypass toggles against the model
    for (int n = 0; n < 60; n++) begin
      int run;
      fault_n_in = ($urandom % 3 == 0) ? 1'b1 : ~fault_n_in;
      if ($urandom % 4 == 0) bypass_en = ~bypass_en;
      run = 1 + ($urandom % 120);
      for (int c = 0; c < run; c++) begin
        @(negedge clk);
        if ($urandom % 40 == 0) bypass_en = ~bypass_en;
      end
    end
    fault_n_in = 1'b1;
    bypass_en = 1'b0;
    repeat (HOLD + 3 * SET) @(negedge clk);
    chk("R4 final idle recov_n", recov_n, 1);
    chk("R6 final irq_n", irq_n, 1);
    finish_run();
  end

endmodule